// File: doc/BRIEF.md
# Four-Deep Shifting Register Stack

This block is a last-in, first-out store built from a short chain of data registers rather than from a memory and a pointer. Every register hands its value to the next one down the chain. New words are written into the top stage, and the block's output always shows the top stage. A push moves the whole chain one place down and loads the input word at the top. A pop moves the whole chain one place up and fills the bottom stage with zero.

Push and pop are single control lines. Exactly one of them being high selects that operation. Both low, or both high, leaves every stage untouched. An occupancy counter from 0 to the stack depth drives full and empty flags. A push into a full stack, or a pop from an empty one, still moves the data, and it also raises a one-cycle error pulse. The width, the depth and whether occupancy tracking is built are all parameters. By default the stack holds four 32-bit words.

Top module: `shift_stack`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every stage to zero and the occupancy to 0. After reset, top_o is 0, empty_o is 1, and full_o and err_o are 0.
- R2: A cycle with push_i=1 and pop_i=0 loads din into the top stage and moves each stage k into stage k+1, all at the same edge. top_o equals that din one edge later.
- R3: A cycle with pop_i=1 and push_i=0 moves each stage k+1 into stage k and loads zero into the bottom stage. top_o then shows the word that was in the second stage.
- R4: A cycle with push_i=0 and pop_i=0 leaves every stage, the occupancy and the flags unchanged.
- R5: top_o always shows the top stage, so words come back in the reverse of the order in which they were pushed.
- R6: A push while all four stages hold data drops the word that was in the bottom stage. Later pops return only the four newest words, followed by zeros.
- R7: full_o is 1 exactly when the occupancy equals the depth (4). empty_o is 1 exactly when the occupancy is 0. The occupancy rises by one on each push and falls by one on each pop, and it never goes outside 0 to 4.
- R8: A push while full still moves the data and keeps the occupancy at 4. err_o is 1 during the cycle after that edge, and only then.
- R9: A pop while empty still moves the data (zeros), keeps the occupancy at 0, and raises err_o for the one cycle after that edge.
- R10: A cycle with push_i=1 and pop_i=1 changes no stage and no occupancy, and it raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| din | input | DATA_W (32) | Word to push |
| top_o | output | DATA_W (32) | Contents of the top stage |
| full_o | output | 1 | Occupancy equals depth |
| empty_o | output | 1 | Occupancy is zero |
| err_o | output | 1 | One-cycle pulse after a push when full or a pop when empty |

## Verification
The stack is driven with four kinds of pattern. The first is a run of pushes of distinct words followed by a full drain, which separates correct LIFO order from a stage that is wired or shifted the wrong way. The second overfills the stack and then pops past empty. This shows whether the oldest word is the one dropped, whether zeros come up from the bottom, and whether the error pulse lasts exactly one cycle. Held-idle cycles and cycles with both controls high are mixed in to show that neither one disturbs data or occupancy. A long pseudo-random mix of all four operations is compared every cycle against a behavioural model built on an array and a count.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_PUSH = 2'd1,
      OP_POP  = 2'd2
   } stk_op_e;

   // exactly one request line high selects an operation; otherwise hold
   function automatic stk_op_e decode_op(input logic push, input logic pop);
      if (push && !pop)      return OP_PUSH;
      else if (pop && !push) return OP_POP;
      else                   return OP_HOLD;
   endfunction

endpackage

// File: rtl/stk_cell.sv
module stk_cell
   import stk_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  stk_op_e           op,
   input  logic [DATA_W-1:0] from_above,
   input  logic [DATA_W-1:0] from_below,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         case (op)
            OP_PUSH: q <= from_above;
            OP_POP:  q <= from_below;
            default: q <= q;
         endcase
      end
   end

   AST_CELL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (op == OP_HOLD) |=> $stable(q)); // R4

endmodule

// File: rtl/stk_fill.sv
module stk_fill
   import stk_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic    clk,
   input  logic    rst,
   input  stk_op_e op,
   output logic    full,
   output logic    empty,
   output logic    err
);

   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         err <= 1'b0;
      end else begin
         err <= 1'b0;
         case (op)
            OP_PUSH: begin
               if (cnt == CNT_MAX) err <= 1'b1;
               else                cnt <= cnt + 1'b1;
            end
            OP_POP: begin
               if (cnt == '0) err <= 1'b1;
               else           cnt <= cnt - 1'b1;
            end
            default: cnt <= cnt;
         endcase
      end
   end

   assign full  = (cnt == CNT_MAX);
   assign empty = (cnt == '0);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNT_MAX); // R7
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(full && empty)); // R7
   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
      err |-> $past((op == OP_PUSH && full) || (op == OP_POP && empty))); // R8
   AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (rst)
      (op == OP_HOLD) |=> ($stable(cnt) && !err)); // R10

endmodule

// File: rtl/shift_stack.sv
module shift_stack
   import stk_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int DEPTH      = 4,
   parameter bit TRACK_FILL = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] top_o,
   output logic              full_o,
   output logic              empty_o,
   output logic              err_o
);

   localparam int LAST = DEPTH - 1;

   if (DATA_W < 1) begin : g_bad_width
      $error("shift_stack: DATA_W must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("shift_stack: DEPTH must be at least 2");
   end

   stk_op_e op;
   assign op = decode_op(push_i, pop_i);

   logic [DATA_W-1:0] stage [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_chain
      logic [DATA_W-1:0] above;
      logic [DATA_W-1:0] below;
      if (g == 0) begin : g_top
         assign above = din;
      end else begin : g_mid_a
         assign above = stage[g-1];
      end
      if (g == LAST) begin : g_bottom
         assign below = '0;
      end else begin : g_mid_b
         assign below = stage[g+1];
      end
      stk_cell #(.DATA_W(DATA_W)) u_cell (
         .clk        (clk),
         .rst        (rst),
         .op         (op),
         .from_above (above),
         .from_below (below),
         .q          (stage[g])
      );
   end

   assign top_o = stage[0];

   if (TRACK_FILL) begin : g_fill
      stk_fill #(.DEPTH(DEPTH)) u_fill (
         .clk   (clk),
         .rst   (rst),
         .op    (op),
         .full  (full_o),
         .empty (empty_o),
         .err   (err_o)
      );
   end else begin : g_nofill
      assign full_o  = 1'b0;
      assign empty_o = 1'b0;
      assign err_o   = 1'b0;
   end

   AST_PUSH_LOADS_TOP: assert property (@(posedge clk) disable iff (rst)
      (push_i && !pop_i) |=> (top_o == $past(din))); // R2
   AST_POP_RAISES_SECOND: assert property (@(posedge clk) disable iff (rst)
      (pop_i && !push_i) |=> (top_o == $past(stage[1]))); // R3
   AST_POP_ZERO_BOTTOM: assert property (@(posedge clk) disable iff (rst)
      (pop_i && !push_i) |=> (stage[LAST] == '0)); // R3
   AST_BOTH_NOOP: assert property (@(posedge clk) disable iff (rst)
      (push_i && pop_i) |=> $stable(top_o)); // R10

endmodule

// File: tb/sim_shift_stack.sv
`timescale 1ns/1ps
module sim_shift_stack;

   logic        clk = 1'b0;
   logic        rst;
   logic        push_i, pop_i;
   logic [31:0] din;
   logic [31:0] top_o;
   logic        full_o, empty_o, err_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   shift_stack u0 (
      .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .din(din),
      .top_o(top_o), .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
   );

   // behavioural reference: array of words plus a fill count
   logic [31:0] m [4];
   int          mcnt;
   logic        merr;

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 4; i++) m[i] <= '0;
         mcnt <= 0;
         merr <= 1'b0;
      end else if (push_i && !pop_i) begin
         m[0] <= din; m[1] <= m[0]; m[2] <= m[1]; m[3] <= m[2];
         merr <= (mcnt == 4);
         if (mcnt < 4) mcnt <= mcnt + 1;
      end else if (pop_i && !push_i) begin
         m[0] <= m[1]; m[1] <= m[2]; m[2] <= m[3]; m[3] <= '0;
         merr <= (mcnt == 0);
         if (mcnt > 0) mcnt <= mcnt - 1;
      end else begin
         merr <= 1'b0;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare(input string tag, input string etag);
      chk(tag, top_o, m[0]);
      chk("R7 full", 32'(full_o), 32'(mcnt == 4));
      chk("R7 empty", 32'(empty_o), 32'(mcnt == 0));
      chk(etag, 32'(err_o), 32'(merr));
   endtask

   task automatic cyc(input logic p, input logic q, input logic [31:0] d,
                      input string tag, input string etag);
      push_i = p; pop_i = q; din = d;
      @(posedge clk);
      @(negedge clk);
      compare(tag, etag);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst = 1'b1; push_i = 0; pop_i = 0; din = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare("R1 reset top", "R1 reset err");
      chk("R1 empty after reset", 32'(empty_o), 32'd1);
      rst = 1'b0;

      // fill with distinct words
      for (int i = 1; i <= 4; i++)
         cyc(1, 0, 32'hA000_0000 + i, "R2 push", "R8 no err");
      chk("R7 full at four", 32'(full_o), 32'd1);
      // overfill: oldest word dropped, one-cycle error
      cyc(1, 0, 32'hA000_0005, "R6 push when full", "R8 err pulse");
      chk("R8 err high", 32'(err_o), 32'd1);
      cyc(0, 0, 32'hDEAD_BEEF, "R4 idle", "R8 err falls");
      chk("R8 err one cycle", 32'(err_o), 32'd0);
      cyc(1, 1, 32'h1234_5678, "R10 both high", "R10 no err");
      chk("R10 top kept", top_o, 32'hA000_0005);
      // drain: reverse order, oldest lost, then zeros
      for (int i = 5; i >= 2; i--) begin
         chk("R5 lifo order", top_o, 32'hA000_0000 + i);
         cyc(0, 1, '0, "R3 pop", "R9 no err");
      end
      chk("R6 zero after drain", top_o, 32'd0);
      chk("R7 empty after drain", 32'(empty_o), 32'd1);
      cyc(0, 1, '0, "R9 pop when empty", "R9 err pulse");
      chk("R9 err high", 32'(err_o), 32'd1);
      cyc(0, 0, '0, "R4 idle", "R9 err falls");

      // mixed traffic
      for (int n = 0; n < 3000; n++) begin
         logic [1:0] sel;
         sel = 2'($urandom_range(0, 3));
         case (sel)
            2'd0: cyc(0, 0, $urandom, "R4 idle", "R4 err");
            2'd1: cyc(1, 0, $urandom, "R2 push", "R8 err");
            2'd2: cyc(0, 1, $urandom, "R3 pop", "R9 err");
            default: cyc(1, 1, $urandom, "R10 both", "R10 err");
         endcase
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule